// File: doc/BRIEF.md
# Microcoded Instruction-Fetch Controller

This block sequences the instruction-fetch part of a processor whose datapath has three buses: two operand buses feeding an ALU and one result bus that writes back into registers. A small micro-memory, read combinationally from a micro-address register, supplies each cycle's control strobes, a branch-condition selector and two explicit 8-bit successor addresses (one for taken, one for not-taken). No micro-address incrementer is needed. The source on the first operand bus is held as a 3-bit encoded field. It is decoded to one-hot enables, so two sources can never drive that bus at once.

A fetch takes four cycles. Cycle one sends the program counter through the ALU into the memory address register and starts a read. Cycle two adds the constant 4 to the program counter. Cycle three moves the returned memory word into the instruction register. Cycle four hands control to the decode entry point. At that point the sequencer waits until the surrounding core reports that the instruction has been handled, then starts the next fetch. A small register model (program counter, memory address, memory buffer, instruction registers) is included so the effect of each strobe is visible.

Top module: `fetch_ctrl`

## Requirements
- R1: While reset is held and just after its release, the micro-address equals the fetch entry (default 0x00), the program counter equals RESET_PC (default 0xFFF0), and the memory address and instruction outputs are zero.
- R2: The 10-bit control word (bit 9 down to 0: program counter onto operand bus 1, constant 4 onto bus 2, buffer onto bus 2, load address reg, load program counter, load instruction reg, ALU add, ALU pass bus 1, ALU pass bus 2, memory read) is 0x245, 0x328, 0x092 and 0x000 in fetch cycles one to four.
- R3: At the end of fetch cycle one the memory address output takes the old program counter. The memory read output is high in that cycle only.
- R4: At the end of fetch cycle two the program counter becomes its old value plus 4, wrapping modulo 2^DATA_W.
- R5: The memory buffer captures the read data on the edge that ends the cycle after the read strobe. At the end of fetch cycle three the instruction output holds the memory word at the address fetched.
- R6: The operand-bus-1 source code is 3 bits: 000 selects no source, 001 the program counter, 010 the address register, 011 the buffer, 100 the instruction register, and 101 to 111 nothing. At most one enable bit is high. Enable bit 0 (program counter) is high in fetch cycles one and two and low otherwise.
- R7: After fetch cycle four the micro-address is the decode entry (default 0x40). It stays there, with program counter and instruction unchanged, while execDone is low. It returns to the fetch entry on the edge where execDone is sampled high.
- R8: execDone has no effect during the four fetch cycles, because their successor fields are equal.
- R9: Bus 2 is never driven by both the constant and the buffer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| execDone | input | 1 | Core has finished with the fetched instruction |
| memRdData | input | DATA_W | Memory read data for memAddr |
| memAddr | output | DATA_W | Memory address register contents |
| memRead | output | 1 | Memory read strobe |
| ctlWord | output | 10 | Horizontal view of the current control strobes |
| b1En | output | 7 | Decoded operand-bus-1 source enables |
| uAddr | output | 8 | Current micro-address |
| pcOut | output | DATA_W | Program counter |
| irOut | output | DATA_W | Instruction register |

## Verification
The micro-memory is read combinationally, so ctlWord, b1En, memRead and uAddr belong to the cycle in which they are shown. Register effects appear one edge later: the address register after cycle one, the program counter after cycle two, the instruction after cycle three (the buffer having loaded one edge before). The bench drives inputs and samples outputs on the falling edge. In each fetch cycle it checks the values due in that cycle, and it compares each register one falling edge after the rising edge that should load it. It sweeps forty back-to-back fetches through the program-counter wrap, with a varying number of decode wait cycles and execDone toggled during fetch cycles.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int B1_SEL_W = 3;
  localparam int UADDR_W  = 8;
  localparam int CTL_W    = 10;

  localparam logic [B1_SEL_W-1:0] B1_NONE = 3'd0;
  localparam logic [B1_SEL_W-1:0] B1_PC   = 3'd1;
  localparam logic [B1_SEL_W-1:0] B1_MAR  = 3'd2;
  localparam logic [B1_SEL_W-1:0] B1_MBR  = 3'd3;
  localparam logic [B1_SEL_W-1:0] B1_IR   = 3'd4;

  typedef struct packed {
    logic [B1_SEL_W-1:0] b1Sel;
    logic fourToB2;
    logic mbrToB2;
    logic ldMar;
    logic ldPc;
    logic ldIr;
    logic aluAdd;
    logic aluTra1;
    logic aluTra2;
    logic memRd;
  } strobe_t;

  typedef enum logic [1:0] {
    COND_NEVER  = 2'd0,
    COND_ALWAYS = 2'd1,
    COND_EXEC   = 2'd2,
    COND_EXEC_N = 2'd3
  } cond_e;

  typedef struct packed {
    strobe_t             st;
    cond_e               cond;
    logic [UADDR_W-1:0]  nextTaken;
    logic [UADDR_W-1:0]  nextSeq;
  } uword_t;
endpackage

// File: rtl/fetch_useq.sv
module fetch_useq
  import fetch_pkg::*;
#(
  parameter logic [UADDR_W-1:0] FETCH_ENTRY  = 8'h00,
  parameter logic [UADDR_W-1:0] DECODE_ENTRY = 8'h40
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               execDone,
  output strobe_t            strobes,
  output logic [UADDR_W-1:0] uAddr
);
  localparam logic [UADDR_W-1:0] PH1 = FETCH_ENTRY;
  localparam logic [UADDR_W-1:0] PH2 = FETCH_ENTRY + 8'd1;
  localparam logic [UADDR_W-1:0] PH3 = FETCH_ENTRY + 8'd2;
  localparam logic [UADDR_W-1:0] PH4 = FETCH_ENTRY + 8'd3;

  logic [UADDR_W-1:0] uPc;
  uword_t             word;
  logic               taken;

  // Micro-memory, read combinationally from the micro-address register.
  always_comb begin
    word           = '0;
    word.cond      = COND_ALWAYS;
    word.nextTaken = FETCH_ENTRY;
    word.nextSeq   = FETCH_ENTRY;
    case (uPc)
      PH1: begin
        word.st.b1Sel   = B1_PC;
        word.st.aluTra1 = 1'b1;
        word.st.ldMar   = 1'b1;
        word.st.memRd   = 1'b1;
        word.cond       = COND_NEVER;
        word.nextTaken  = PH2;
        word.nextSeq    = PH2;
      end
      PH2: begin
        word.st.b1Sel    = B1_PC;
        word.st.fourToB2 = 1'b1;
        word.st.aluAdd   = 1'b1;
        word.st.ldPc     = 1'b1;
        word.cond        = COND_NEVER;
        word.nextTaken   = PH3;
        word.nextSeq     = PH3;
      end
      PH3: begin
        word.st.mbrToB2 = 1'b1;
        word.st.aluTra2 = 1'b1;
        word.st.ldIr    = 1'b1;
        word.cond       = COND_NEVER;
        word.nextTaken  = PH4;
        word.nextSeq    = PH4;
      end
      PH4: begin
        word.cond      = COND_NEVER;
        word.nextTaken = DECODE_ENTRY;
        word.nextSeq   = DECODE_ENTRY;
      end
      DECODE_ENTRY: begin
        word.cond      = COND_EXEC;
        word.nextTaken = FETCH_ENTRY;
        word.nextSeq   = DECODE_ENTRY;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (word.cond)
      COND_ALWAYS: taken = 1'b1;
      COND_EXEC:   taken = execDone;
      COND_EXEC_N: taken = ~execDone;
      default:     taken = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) uPc <= FETCH_ENTRY;
    else       uPc <= taken ? word.nextTaken : word.nextSeq;
  end

  assign strobes = word.st;
  assign uAddr   = uPc;

  a_r2_ph1_to_ph2: assert property (@(posedge clk) disable iff (!rstN)
    (uPc == PH1) |=> (uPc == PH2));
  a_r8_ph3_to_ph4: assert property (@(posedge clk) disable iff (!rstN)
    (uPc == PH3) |=> (uPc == PH4));
  a_r7_enter_decode: assert property (@(posedge clk) disable iff (!rstN)
    (uPc == PH4) |=> (uPc == DECODE_ENTRY));
  a_r7_wait: assert property (@(posedge clk) disable iff (!rstN)
    (uPc == DECODE_ENTRY && !execDone) |=> (uPc == DECODE_ENTRY));
  a_r7_resume: assert property (@(posedge clk) disable iff (!rstN)
    (uPc == DECODE_ENTRY && execDone) |=> (uPc == FETCH_ENTRY));
endmodule

// File: rtl/fetch_regs.sv
module fetch_regs
  import fetch_pkg::*;
#(
  parameter int                DATA_W     = 16,
  parameter logic [DATA_W-1:0] RESET_PC   = 16'hFFF0,
  parameter int                NUM_B1_SRC = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               st,
  input  logic [DATA_W-1:0]     memRdData,
  output logic [DATA_W-1:0]     pcOut,
  output logic [DATA_W-1:0]     marOut,
  output logic [DATA_W-1:0]     irOut,
  output logic [NUM_B1_SRC-1:0] b1En
);
  localparam logic [DATA_W-1:0] PC_STEP = DATA_W'(4);

  logic [DATA_W-1:0] pc, mar, mbr, ir;
  logic              rdPending;
  logic [DATA_W-1:0] bus1, bus2, bus3;
  logic [DATA_W-1:0] srcVec [NUM_B1_SRC];

  // Vertical source field decoded to one enable per source.
  for (genvar i = 0; i < NUM_B1_SRC; i++) begin : g_b1
    assign b1En[i] = (st.b1Sel == B1_SEL_W'(i + 1));
    if (i == 0)      begin : g_pc  assign srcVec[i] = pc;  end
    else if (i == 1) begin : g_mar assign srcVec[i] = mar; end
    else if (i == 2) begin : g_mbr assign srcVec[i] = mbr; end
    else if (i == 3) begin : g_ir  assign srcVec[i] = ir;  end
    else             begin : g_nc  assign srcVec[i] = '0;  end
  end

  always_comb begin
    bus1 = '0;
    for (int i = 0; i < NUM_B1_SRC; i++)
      bus1 = bus1 | (srcVec[i] & {DATA_W{b1En[i]}});
  end

  assign bus2 = (st.fourToB2 ? PC_STEP : '0) | (st.mbrToB2 ? mbr : '0);

  always_comb begin
    if (st.aluAdd)       bus3 = bus1 + bus2;
    else if (st.aluTra1) bus3 = bus1;
    else if (st.aluTra2) bus3 = bus2;
    else                 bus3 = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc        <= RESET_PC;
      mar       <= '0;
      mbr       <= '0;
      ir        <= '0;
      rdPending <= 1'b0;
    end else begin
      rdPending <= st.memRd;
      if (rdPending) mbr <= memRdData;
      if (st.ldMar)  mar <= bus3;
      if (st.ldPc)   pc  <= bus3;
      if (st.ldIr)   ir  <= bus3;
    end
  end

  assign pcOut  = pc;
  assign marOut = mar;
  assign irOut  = ir;

  a_r6_b1_single: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(b1En));
  a_r9_b2_single: assert property (@(posedge clk) disable iff (!rstN)
    !(st.fourToB2 && st.mbrToB2));
  a_r3_mar_gets_pc: assert property (@(posedge clk) disable iff (!rstN)
    st.ldMar |=> (mar == $past(pc)));
  a_r4_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    st.ldPc |=> (pc == $past(pc) + PC_STEP));
  a_r7_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !st.ldPc |=> $stable(pc));
  a_r5_ir_from_mbr: assert property (@(posedge clk) disable iff (!rstN)
    st.ldIr |=> (ir == $past(mbr)));
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
#(
  parameter int                 DATA_W       = 16,
  parameter logic [DATA_W-1:0]  RESET_PC     = 16'hFFF0,
  parameter logic [UADDR_W-1:0] FETCH_ENTRY  = 8'h00,
  parameter logic [UADDR_W-1:0] DECODE_ENTRY = 8'h40
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               execDone,
  input  logic [DATA_W-1:0]  memRdData,
  output logic [DATA_W-1:0]  memAddr,
  output logic               memRead,
  output logic [CTL_W-1:0]   ctlWord,
  output logic [6:0]         b1En,
  output logic [UADDR_W-1:0] uAddr,
  output logic [DATA_W-1:0]  pcOut,
  output logic [DATA_W-1:0]  irOut
);
  strobe_t strobes;

  fetch_useq #(
    .FETCH_ENTRY (FETCH_ENTRY),
    .DECODE_ENTRY(DECODE_ENTRY)
  ) u_useq (
    .clk     (clk),
    .rstN    (rstN),
    .execDone(execDone),
    .strobes (strobes),
    .uAddr   (uAddr)
  );

  fetch_regs #(
    .DATA_W    (DATA_W),
    .RESET_PC  (RESET_PC),
    .NUM_B1_SRC(7)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .st       (strobes),
    .memRdData(memRdData),
    .pcOut    (pcOut),
    .marOut   (memAddr),
    .irOut    (irOut),
    .b1En     (b1En)
  );

  assign memRead = strobes.memRd;
  assign ctlWord = {b1En[0], strobes.fourToB2, strobes.mbrToB2, strobes.ldMar,
                    strobes.ldPc, strobes.ldIr, strobes.aluAdd, strobes.aluTra1,
                    strobes.aluTra2, strobes.memRd};
endmodule

// File: tb/fetch_ctrl_tb.sv
module fetch_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam logic [7:0] F0 = 8'h00;
  localparam logic [7:0] DEC = 8'h40;
  localparam int NFETCH = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic execDone = 1'b0;
  logic [DW-1:0] memRdData, memAddr, pcOut, irOut;
  logic memRead;
  logic [9:0] ctlWord;
  logic [6:0] b1En;
  logic [7:0] uAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
    return (a * 16'h9E37) ^ 16'h5A3C;
  endfunction

  assign memRdData = memf(memAddr);

  fetch_ctrl u_dut (
    .clk(clk), .rstN(rstN), .execDone(execDone), .memRdData(memRdData),
    .memAddr(memAddr), .memRead(memRead), .ctlWord(ctlWord), .b1En(b1En),
    .uAddr(uAddr), .pcOut(pcOut), .irOut(irOut)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    logic [DW-1:0] pcOld;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk(uAddr == F0, "R1 uAddr", uAddr, F0);
    chk(pcOut == 16'hFFF0, "R1 pc", pcOut, 16'hFFF0);
    chk(memAddr == 0, "R1 mar", memAddr, 0);
    chk(irOut == 0, "R1 ir", irOut, 0);
    rstN = 1'b1;
    chk(uAddr == F0, "R1 uAddr after release", uAddr, F0);
    for (int n = 0; n < NFETCH; n++) begin
      // fetch cycle one; execDone toggles to show it is ignored (R8)
      pcOld = pcOut;
      chk(uAddr == F0, "R8 cycle1 addr", uAddr, F0);
      chk(ctlWord == 10'h245, "R2 cycle1 word", ctlWord, 10'h245);
      chk(b1En == 7'b0000001, "R6 cycle1 b1", b1En, 7'b0000001);
      chk(memRead == 1'b1, "R3 read high", memRead, 1);
      chk(!(ctlWord[8] && ctlWord[7]), "R9 bus2", ctlWord, 0);
      execDone = n[0];
      @(negedge clk);
      chk(uAddr == F0 + 8'd1, "R8 cycle2 addr", uAddr, F0 + 8'd1);
      chk(ctlWord == 10'h328, "R2 cycle2 word", ctlWord, 10'h328);
      chk(b1En == 7'b0000001, "R6 cycle2 b1", b1En, 7'b0000001);
      chk(memAddr == pcOld, "R3 mar", memAddr, pcOld);
      chk(memRead == 1'b0, "R3 read low", memRead, 0);
      execDone = ~n[0];
      @(negedge clk);
      chk(uAddr == F0 + 8'd2, "R8 cycle3 addr", uAddr, F0 + 8'd2);
      chk(ctlWord == 10'h092, "R2 cycle3 word", ctlWord, 10'h092);
      chk(b1En == 7'b0, "R6 cycle3 b1", b1En, 0);
      chk(pcOut == DW'(pcOld + 16'd4), "R4 pc+4", pcOut, DW'(pcOld + 16'd4));
      execDone = 1'b1;
      @(negedge clk);
      chk(ctlWord == 10'h000, "R2 cycle4 word", ctlWord, 0);
      chk(irOut == memf(pcOld), "R5 ir", irOut, memf(pcOld));
      chk(b1En == 7'b0, "R6 cycle4 b1", b1En, 0);
      execDone = 1'b0;
      @(negedge clk);
      chk(uAddr == DEC, "R7 at decode", uAddr, DEC);
      for (int w = 0; w < n % 4; w++) begin
        @(negedge clk);
        chk(uAddr == DEC, "R7 waiting", uAddr, DEC);
        chk(pcOut == DW'(pcOld + 16'd4), "R7 pc held", pcOut, DW'(pcOld + 16'd4));
        chk(irOut == memf(pcOld), "R7 ir held", irOut, memf(pcOld));
      end
      execDone = 1'b1;
      @(negedge clk);
      execDone = 1'b0;
      chk(uAddr == F0, "R7 resume", uAddr, F0);
    end
    summary();
  end
endmodule